// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two bidirectional data buses, called side A and side B. Each side has a capture register with its own clock. The A register samples the A bus on every rising edge of `clk_a`, and the B register samples the B bus on every rising edge of `clk_b`. Capture does not depend on the drive controls. This lets the block hold a word from either bus while both buses are isolated.

Data flows in two directions.
- Toward A, the output is either the live B bus value or the stored B word.
- Toward B, the output is either the live A bus value or the stored A word.

The choice toward A is made by `sel_b2a` and the choice toward B by `sel_a2b`. An active-low `oe_n` and a `dir` input decide which bus, if any, the block drives. Each three-state pin is modelled as an input, an output and an output enable, so the integrating level can build the pad.

The buses are transparent wires, not streams. There is no valid/ready handshake and no back-pressure. A word is taken when a register clock rises, and a live word passes through in the same cycle.

Top module: `bus_xcvr_reg`

## Requirements
- R1: On each rising edge of `clk_a` with `rst_n` high, the A register takes `a_in`, whatever the values of `oe_n` and `dir`.
- R2: On each rising edge of `clk_b` with `rst_n` high, the B register takes `b_in`, whatever the values of `oe_n` and `dir`.
- R3: A rising edge of a register's clock while `rst_n` is low clears that register to zero.
- R4: While `oe_n` is 1, both `a_oe` and `b_oe` are 0.
- R5: While `oe_n` is 0, `dir` = 0 gives `a_oe` = 1 and `b_oe` = 0, and `dir` = 1 gives `b_oe` = 1 and `a_oe` = 0.
- R6: While `sel_b2a` is 0, `a_out` equals `b_in` in the same cycle, with no register in the path.
- R7: While `sel_b2a` is 1, `a_out` equals the B register.
- R8: While `sel_a2b` is 0, `b_out` equals `a_in` in the same cycle.
- R9: While `sel_a2b` is 1, `b_out` equals the A register.
- R10: `a_oe` and `b_oe` are never both 1.
- R11: When the live and stored words are equal, toggling the select leaves that output with no transition at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Capture clock of the A register |
| clk_b | input | 1 | Capture clock of the B register |
| rst_n | input | 1 | Active-low synchronous clear of both registers |
| oe_n | input | 1 | Active-low bus drive enable |
| dir | input | 1 | Drive direction: 0 drives A, 1 drives B |
| sel_a2b | input | 1 | Source toward B: 0 live A, 1 stored A |
| sel_b2a | input | 1 | Source toward A: 0 live B, 1 stored B |
| a_in | input | WIDTH | Value seen on the A pins |
| a_out | output | WIDTH | Value to put on the A pins |
| a_oe | output | 1 | Drive enable of the A pins |
| b_in | input | WIDTH | Value seen on the B pins |
| b_out | output | WIDTH | Value to put on the B pins |
| b_oe | output | 1 | Drive enable of the B pins |

## Verification
The bench builds the block with `WIDTH` = 8. With that width, random bytes quickly hit words where every bit differs between the live and stored values, as well as words where the two are equal. This exercises the per-bit hazard cover both when it must switch and when it must stay quiet.

The two clocks are pulsed independently, including cycles where one, both or neither capture. This shows that each register only follows its own clock while `oe_n` and `dir` roam freely.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic [1:0] {
    DRV_NONE = 2'b00,
    DRV_A    = 2'b01,
    DRV_B    = 2'b10
  } drive_e;
endpackage

// File: rtl/xcvr_capture_reg.sv
module xcvr_capture_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

  AST_CAPTURE_TAKES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> q == $past(d)); // R1 R2

  AST_CLEAR_ON_RESET: assert property (@(posedge clk)
    !rst_n |=> q == '0); // R3
endmodule

// File: rtl/xcvr_path_mux.sv
module xcvr_path_mux #(
  parameter int WIDTH = 8
) (
  input  logic             sel,
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] stored,
  output logic [WIDTH-1:0] y
);
  logic [WIDTH-1:0] pick;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      pick[i] = (live[i] & ~sel) | (stored[i] & sel) | (live[i] & stored[i]);
    end
  end

  assign y = pick;

  always_comb begin
    if (live == stored && !$isunknown(live))
      AST_NO_GLITCH: assert (y == live); // R11
  end
endmodule

// File: rtl/xcvr_drive_decode.sv
module xcvr_drive_decode
  import xcvr_pkg::*;
(
  input  logic oe_n,
  input  logic dir,
  output logic a_oe,
  output logic b_oe
);
  drive_e side;

  always_comb begin
    if (oe_n)     side = DRV_NONE;
    else if (dir) side = DRV_B;
    else          side = DRV_A;
  end

  assign a_oe = (side == DRV_A);
  assign b_oe = (side == DRV_B);
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk_a,
  input  logic             clk_b,
  input  logic             rst_n,
  input  logic             oe_n,
  input  logic             dir,
  input  logic             sel_a2b,
  input  logic             sel_b2a,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe
);
  logic [WIDTH-1:0] store_a;
  logic [WIDTH-1:0] store_b;

  xcvr_capture_reg #(.WIDTH(WIDTH)) u_reg_a (
    .clk(clk_a), .rst_n(rst_n), .d(a_in), .q(store_a)
  );

  xcvr_capture_reg #(.WIDTH(WIDTH)) u_reg_b (
    .clk(clk_b), .rst_n(rst_n), .d(b_in), .q(store_b)
  );

  xcvr_path_mux #(.WIDTH(WIDTH)) u_mux_to_b (
    .sel(sel_a2b), .live(a_in), .stored(store_a), .y(b_out)
  );

  xcvr_path_mux #(.WIDTH(WIDTH)) u_mux_to_a (
    .sel(sel_b2a), .live(b_in), .stored(store_b), .y(a_out)
  );

  xcvr_drive_decode u_decode (
    .oe_n(oe_n), .dir(dir), .a_oe(a_oe), .b_oe(b_oe)
  );

  AST_ONE_SIDE_DRIVEN: assert property (@(posedge clk_a) disable iff (!rst_n)
    !(a_oe && b_oe)); // R10

  AST_ISOLATE: assert property (@(posedge clk_a) disable iff (!rst_n)
    oe_n |-> (!a_oe && !b_oe)); // R4

  AST_REPLAY_TO_B: assert property (@(posedge clk_a) disable iff (!rst_n)
    sel_a2b |-> b_out == store_a); // R9

  AST_REPLAY_TO_A: assert property (@(posedge clk_b) disable iff (!rst_n)
    sel_b2a |-> a_out == store_b); // R7
endmodule

// File: tb/bus_xcvr_reg_test.sv
module bus_xcvr_reg_test;
  localparam int W = 8;

  logic clk = 1'b0;
  logic clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
  logic oe_n = 1'b1, dir = 1'b0, sel_a2b = 1'b0, sel_b2a = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic a_oe, b_oe;

  int checks = 0, fails = 0;
  logic [W-1:0] ma = '0, mb = '0;
  bit done = 0;
  bit watch = 0;
  int edges = 0;

  always #2.5 clk = ~clk;

  bus_xcvr_reg #(.WIDTH(W)) uut (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .oe_n(oe_n), .dir(dir),
    .sel_a2b(sel_a2b), .sel_b2a(sel_b2a), .a_in(a_in), .a_out(a_out),
    .a_oe(a_oe), .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  always @(b_out) if (watch) edges++;

  function automatic logic [W-1:0] exp_a_out();
    return sel_b2a ? mb : b_in;
  endfunction

  function automatic logic [W-1:0] exp_b_out();
    return sel_a2b ? ma : a_in;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk(oe_n ? "R4" : "R5", {7'd0, a_oe}, {7'd0, !oe_n && !dir});
    chk(oe_n ? "R4" : "R5", {7'd0, b_oe}, {7'd0, !oe_n && dir});
    chk("R10", {7'd0, a_oe & b_oe}, 8'd0);
    chk(sel_b2a ? "R7" : "R6", a_out, exp_a_out());
    chk(sel_a2b ? "R9" : "R8", b_out, exp_b_out());
  endtask

  task automatic step(input bit ca, input bit cb);
    @(posedge clk);
    clk_a = ca;
    clk_b = cb;
    if (ca) ma = rst_n ? a_in : '0;
    if (cb) mb = rst_n ? b_in : '0;
    @(negedge clk);
    clk_a = 1'b0;
    clk_b = 1'b0;
    #1 check_all();
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    void'($urandom(32'd1646));
    a_in = 8'hC3; b_in = 8'h3C;
    step(1, 1);
    step(1, 1);
    rst_n = 1'b1;
    sel_a2b = 1'b1; sel_b2a = 1'b1;
    #1;
    chk("R3", b_out, 8'h00);
    chk("R3", a_out, 8'h00);

    // R1 R2: capture with outputs isolated, then replay
    oe_n = 1'b1; a_in = 8'hA5; b_in = 8'h5A;
    step(1, 0);
    chk("R1", b_out, 8'hA5);
    chk("R2", a_out, 8'h00);
    step(0, 1);
    chk("R2", a_out, 8'h5A);
    oe_n = 1'b0; dir = 1'b1; a_in = 8'h00; b_in = 8'hFF;
    step(0, 0);
    chk("R1", b_out, 8'hA5);

    // R6 R8: live path is combinational
    sel_a2b = 1'b0; sel_b2a = 1'b0;
    a_in = 8'h81; b_in = 8'h7E;
    #1;
    chk("R8", b_out, 8'h81);
    chk("R6", a_out, 8'h7E);

    for (int i = 0; i < 400; i++) begin
      oe_n = $urandom_range(0, 3) == 0;
      dir = $urandom_range(0, 1) != 0;
      sel_a2b = $urandom_range(0, 1) != 0;
      sel_b2a = $urandom_range(0, 1) != 0;
      a_in = W'($urandom);
      b_in = ($urandom_range(0, 4) == 0) ? mb : W'($urandom);
      if ($urandom_range(0, 5) == 0) a_in = ma;
      step($urandom_range(0, 1) != 0, $urandom_range(0, 1) != 0);
    end

    // R11: toggle select with equal live and stored words
    a_in = 8'h96;
    step(1, 0);
    sel_a2b = 1'b0;
    #1;
    watch = 1; edges = 0;
    for (int k = 0; k < 6; k++) begin
      sel_a2b = ~sel_a2b;
      #1 chk("R11", b_out, 8'h96);
    end
    watch = 0;
    chk("R11", edges[7:0], 8'd0);

    // R3: mid-run reset clears only the pulsed register
    rst_n = 1'b0; sel_a2b = 1'b1; sel_b2a = 1'b1;
    mb = mb;
    step(1, 0);
    chk("R3", b_out, 8'h00);
    rst_n = 1'b1;
    step(0, 0);
    finish_up();
  end

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end
endmodule